// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

The block turns one PWM waveform into a high-side and a low-side drive signal that are never high together. The high side follows the waveform going high and the low side follows it going low. Each of these turn-on transitions is held back by its own programmable dead time, so the switch that is turning off has time to open before its partner closes. Turn-off transitions are not delayed beyond the one register stage every output has.

The dead time is counted by a 4-bit down counter. A prescaler divides the timer clock by 1, 2, 4 or 8 and advances the counter. Every edge of the waveform reloads the counter from the dead-time value of the side that is about to turn on and restarts the prescaler, so the delay is an exact number of clocks. A single enable stands for "PWM running with complementary outputs selected". While it is low, both outputs are held low. When it rises, the current waveform level is treated as a fresh edge.

Top module: `pwm_deadtime`

## Requirements
- R1: `presc_sel` codes 0, 1, 2 and 3 give a divide factor D of 1, 2, 4 and 8. The prescaler restarts on every sampled waveform edge and while `enable` is low.
- R2: If the clock edge k is the first to sample `wave_in` high, `out_hi` goes high at edge k + (`dt_high` + 1) * D, provided the input holds until then.
- R3: If the clock edge k is the first to sample `wave_in` low, `out_lo` goes high at edge k + (`dt_low` + 1) * D, provided the input holds until then.
- R4: The output that turns off goes low at the edge that samples the waveform change, with no dead time added.
- R5: A dead-time value of 0 still delays the turn-on by D clocks, and by at least one clock.
- R6: `out_hi` and `out_lo` are never both high.
- R7: An input edge that arrives at or before the end of the running count reloads the counter for the new direction. The output that was waiting never goes high.
- R8: While `enable` is sampled low, both outputs are low from the next edge. When edge e is the first to sample `enable` high, the output matching the current `wave_in` level goes high at edge e - 1 + (dead time + 1) * D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wave_in | input | 1 | PWM waveform from the waveform generator |
| enable | input | 1 | PWM running with complementary outputs selected |
| presc_sel | input | 2 | Dead-time prescaler select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| dt_high | input | 4 | Dead time before the high side turns on, in prescaled ticks |
| dt_low | input | 4 | Dead time before the low side turns on, in prescaled ticks |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side drive |

## Verification
Each prescale setting is run with unequal high and low dead times, so a swapped reload value or a wrong divide factor moves the measured edge-to-rise distance. Long input pulses measure the exact delay. Pulses shorter than the dead time, and pulses whose length equals it, separate a correct reload from a counter that lets the pending output through or lets it through one clock early. A zero dead time with single-clock pulses exposes a missing minimum stage. Enabling and disabling mid-waveform tests that both outputs are forced low and that the first turn-on is timed from the last disabled clock.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_ON   = 1'b1
  } dt_phase_e;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_LOG = (1 << SEL_W) - 1;
  localparam int PC_W    = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [PC_W-1:0] pcnt_q, pcnt_d, limit;

  always_comb begin
    limit = {PC_W{1'b1}} >> (MAX_LOG - int'(sel));
    tick  = (pcnt_q == limit);
  end

  always_comb begin
    if (clr || tick) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R1: with a divide above one, ticks are single-cycle strobes
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || !$stable(sel)));
endmodule

// File: rtl/dt_edge_detect.sv
module dt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wave_in,
  output logic level,
  output logic edge_pulse
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= wave_in;
  end

  assign level      = level_q;
  assign edge_pulse = wave_in ^ level_q;
endmodule

// File: rtl/dt_counter.sv
module dt_counter
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             edge_pulse,
  input  logic             wave_in,
  input  logic [CNT_W-1:0] dt_hi,
  input  logic [CNT_W-1:0] dt_lo,
  input  logic             tick,
  output logic             done
);
  dt_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_zero;

  always_comb begin
    load_val = wave_in ? dt_hi : dt_lo;
    cnt_zero = (cnt_q == '0);
    done     = en && !edge_pulse && (phase_q == PH_WAIT) && tick && cnt_zero;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!en || edge_pulse) begin
      phase_d = PH_WAIT;
      cnt_d   = load_val;
    end else if (phase_q == PH_WAIT && tick) begin
      if (cnt_zero) phase_d = PH_ON;
      else          cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: a running count steps down by one on each tick
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !edge_pulse && phase_q == PH_WAIT && tick && !cnt_zero)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7: an input edge always restarts the wait phase
  assert_edge_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> (phase_q == PH_WAIT));
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wave_in,
  input  logic             enable,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [CNT_W-1:0] dt_high,
  input  logic [CNT_W-1:0] dt_low,
  output logic             out_hi,
  output logic             out_lo
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic       level, edge_pulse, tick, done;
  logic       hi_q, lo_q, hi_d, lo_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  dt_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wave_in    (wave_in),
    .level      (level),
    .edge_pulse (edge_pulse)
  );

  dt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (!enable || edge_pulse),
    .sel   (presc_sel),
    .tick  (tick)
  );

  dt_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_ns),
    .en         (enable),
    .edge_pulse (edge_pulse),
    .wave_in    (wave_in),
    .dt_hi      (dt_high),
    .dt_lo      (dt_low),
    .tick       (tick),
    .done       (done)
  );

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (!enable || edge_pulse) begin
      hi_d = 1'b0;
      lo_d = 1'b0;
    end else if (done) begin
      hi_d = level;
      lo_d = !level;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign out_hi = hi_q;
  assign out_lo = lo_q;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    !(out_hi && out_lo));
  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !enable |=> (!out_hi && !out_lo));
  assert_edge_off_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    edge_pulse |=> (!out_hi && !out_lo));
  assert_hi_after_count_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(out_hi) |-> $past(done));
  assert_lo_after_count_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(out_lo) |-> $past(done));
endmodule

// File: tb/pwm_deadtime_bench.sv
module pwm_deadtime_bench;
  typedef struct {
    bit side;
    int cyc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wave_in = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic [3:0] dt_high = 4'd0;
  logic [3:0] dt_low = 4'd0;
  logic       out_hi, out_lo;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   lvl = 1'b0;
  bit   prev_hi = 1'b0;
  bit   prev_lo = 1'b0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_deadtime u_pwm_deadtime (
    .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .enable(enable),
    .presc_sel(presc_sel), .dt_high(dt_high), .dt_low(dt_low),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  function automatic int div_f();
    return 1 << presc_sel;
  endfunction

  function automatic int delay_f(bit side);
    return ((side ? int'(dt_high) : int'(dt_low)) + 1) * div_f();
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Monitor: overlap on every cycle, each rise popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(!(out_hi && out_lo), "R6 overlap", {out_hi, out_lo}, 0);
      if ((out_hi && !prev_hi) || (out_lo && !prev_lo)) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected rise", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_hi == e.side, e.side ? "R2 rise side" : "R3 rise side",
                int'(out_hi), int'(e.side));
          check(cyc == e.cyc, e.side ? "R2 rise cycle" : "R3 rise cycle", cyc, e.cyc);
        end
      end
      prev_hi = out_hi;
      prev_lo = out_lo;
    end
  end

  task automatic toggle(int hold);
    bit nv;
    int k, dly;
    nv = !lvl;
    lvl = nv;
    wave_in = nv;
    k = cyc + 1;
    dly = delay_f(nv);
    if (dly < hold) q.push_back('{nv, k + dly});
    @(negedge clk);
    check(!out_hi && !out_lo, "R4 off at edge", {out_hi, out_lo}, 0);
    repeat (hold - 1) @(negedge clk);
    if (dly >= hold)
      check((nv ? out_hi : out_lo) == 1'b0, "R7 pending held low", 1, 0);
  endtask

  task automatic start_enable(int hold);
    enable = 1'b1;
    q.push_back('{lvl, cyc + delay_f(lvl)});
    repeat (hold) @(negedge clk);
  endtask

  task automatic stop_enable(int sel, int dh, int dl);
    check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    enable = 1'b0;
    @(negedge clk);
    check(!out_hi && !out_lo, "R8 disabled low", {out_hi, out_lo}, 0);
    presc_sel = 2'(sel);
    dt_high = 4'(dh);
    dt_low = 4'(dl);
    wave_in = !wave_in;
    lvl = wave_in;
    repeat (3) @(negedge clk);
    check(!out_hi && !out_lo, "R8 toggling while disabled", {out_hi, out_lo}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_hi && !out_lo, "R8 reset state", {out_hi, out_lo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5: zero dead time at divide 1
    start_enable(6);
    toggle(5); toggle(5); toggle(1); toggle(1); toggle(2); toggle(2); toggle(3);
    // R1 divide 2, unequal dead times: 8 and 12 clocks
    stop_enable(1, 3, 5);
    start_enable(20);
    toggle(20); toggle(20); toggle(5); toggle(20); toggle(8); toggle(20);
    toggle(12); toggle(20); toggle(13); toggle(9);
    // R1 divide 4: 12 and 8 clocks
    stop_enable(2, 2, 1);
    start_enable(20);
    toggle(20); toggle(20); toggle(12); toggle(9); toggle(13); toggle(8); toggle(3); toggle(15);
    // R1 divide 8: 128 and 8 clocks, R5 minimum of one tick
    stop_enable(3, 15, 0);
    start_enable(140);
    toggle(140); toggle(140); toggle(60); toggle(9); toggle(128); toggle(129); toggle(20);
    // R8: disable while a side is on, re-enable mid-level
    stop_enable(0, 6, 2);
    start_enable(12);
    toggle(12); toggle(4);
    enable = 1'b0;
    @(negedge clk);
    check(!out_hi && !out_lo, "R8 disable mid-count", {out_hi, out_lo}, 0);
    while (q.size() > 0) void'(q.pop_back());
    repeat (4) @(negedge clk);
    start_enable(12);
    toggle(12);
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule